// File: doc/BRIEF.md
# EPP Host Port Transfer Controller

This block is the host end of an Enhanced Parallel Port link. A small CPU register bus reaches two byte-wide registers: one for the address and one for data. When the port is set up for EPP operation, each access to one of these registers runs one handshaked address or data transfer on the parallel port pins. The block drives the write line and the two strobes. It drives the data lines for writes and releases them for reads. It follows the peripheral's wait line through every phase of the transfer. A programmable timeout ends a transfer whose peripheral never answers.

Two inputs from elsewhere gate the register accesses: a 3-bit port mode field and an automatic-mode flag. Writes take effect only in EPP mode with the automatic flag clear. Reads are always answered. In EPP mode a read fetches a fresh byte from the peripheral. In any other mode it returns the byte already held, and the pins stay quiet. A transfer in progress stalls the register bus.

Top module: `epp_host_port`

## Requirements
- R1: After reset both strobes and the write line are high, the data lines are not driven, `cpu_ready` is 1, `cpu_rvalid` is 0 and `timeout_flag` is 0.
- R2: A write is permitted when `auto_mode` is 0 and `mode_sel` is 3'b100. A permitted write to offset 3 runs an address-write transfer, and a permitted write to offset 4 runs a data-write transfer. In both cases the write line is low, the byte is driven with `pp_doe` high, and only the matching strobe goes low (`pp_nastrb` for offset 3, `pp_ndstrb` for offset 4).
- R3: A write made while `auto_mode` is 1 or `mode_sel` is not 3'b100 causes no strobe and does not change the addressed register.
- R4: A transfer has four phases. In the setup cycle the write line and data are set with both strobes high. The strobe then stays low until `pp_nwait` is sampled high, and is released in the next cycle. The transfer ends once `pp_nwait` is sampled low. The strobe is low for exactly as many cycles as the peripheral takes to raise `pp_nwait`.
- R5: With `mode_sel` at 3'b100, a read of offset 3 or 4 runs a read transfer whatever the value of `auto_mode`. The write line stays high and the data lines are released. The byte on `pp_din` is stored when `pp_nwait` is sampled high, and that byte is returned on `cpu_rdata` with a one-cycle `cpu_rvalid` after the transfer ends.
- R6: With `mode_sel` not 3'b100, a read of offset 3 or 4 returns the held byte with `cpu_rvalid` in the cycle after acceptance. It causes no strobe, and `cpu_ready` stays 1.
- R7: While a transfer runs, `cpu_ready` is 0 and register requests are dropped. They neither start a transfer nor change a register.
- R8: When `timeout_limit` is non-zero and the peripheral leaves `pp_nwait` unchanged for `timeout_limit` cycles in a waiting phase, the transfer is aborted. The strobes are released, the write line returns high, the block goes idle, and `timeout_flag` sets and stays set until reset. A limit of 0 disables the timeout.
- R9: Accesses to any offset other than 3 or 4 are ignored. They cause no port activity and no `cpu_rvalid`.
- R10: The two strobes are never low together, and the data lines are driven only while the write line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Register access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Register offset |
| cpu_wdata | input | DW | Write byte |
| cpu_ready | output | 1 | Request accepted this cycle (no transfer running) |
| cpu_rvalid | output | 1 | Read data valid pulse |
| cpu_rdata | output | DW | Read data |
| mode_sel | input | 3 | Port mode field; 3'b100 selects EPP |
| auto_mode | input | 1 | Automatic-mode flag; blocks writes when 1 |
| timeout_limit | input | TO_W | Wait limit in cycles; 0 disables |
| timeout_flag | output | 1 | Sticky abort indication |
| pp_nwrite | output | 1 | Active-low write line |
| pp_nastrb | output | 1 | Active-low address strobe |
| pp_ndstrb | output | 1 | Active-low data strobe |
| pp_nwait | input | 1 | Peripheral wait handshake |
| pp_dout | output | DW | Data lines, outgoing value |
| pp_doe | output | 1 | Data line output enable |
| pp_din | input | DW | Data lines, incoming value |

## Verification
The bench builds the block with TO_W=4, so the largest timeout limit is 15 cycles. This lets it abort a transfer after a five-cycle limit and also hold a strobe for 20 cycles with the timeout disabled, longer than any limit could express, within a short run. ADDR_W stays at 3, which leaves offsets 0 and 5 free as unused addresses. The peripheral model uses response delays of 1 and 3 cycles, so the strobe width tracks the wait line rather than a fixed count.

// File: rtl/epp_host_pkg.sv
package epp_host_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_SETUP   = 2'd1,
    SEQ_STROBE  = 2'd2,
    SEQ_RELEASE = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic is_read;
    logic is_addr;
  } cyc_kind_t;

  localparam logic [2:0] MODE_EPP = 3'b100;

endpackage

// File: rtl/epp_req_gate.sv
module epp_req_gate
  import epp_host_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int ADDR_OFS = 3,
  parameter int DATA_OFS = 4
) (
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [2:0]        mode_sel,
  input  logic              auto_mode,
  input  logic              seq_busy,
  output logic              launch,
  output cyc_kind_t         launch_kind,
  output logic              reg_wr,
  output logic              quick_rd,
  output logic              sel_idx
);

  logic accept;
  logic hit_addr;
  logic hit_data;
  logic hit_any;
  logic epp_on;
  logic wr_allowed;

  always_comb begin
    accept     = cpu_req && !seq_busy;
    hit_addr   = (cpu_addr == ADDR_W'(ADDR_OFS));
    hit_data   = (cpu_addr == ADDR_W'(DATA_OFS));
    hit_any    = hit_addr || hit_data;
    epp_on     = (mode_sel == MODE_EPP);
    wr_allowed = epp_on && !auto_mode;

    sel_idx    = hit_data;
    launch_kind.is_read = !cpu_we;
    launch_kind.is_addr = hit_addr;

    launch   = accept && hit_any && (cpu_we ? wr_allowed : epp_on);
    reg_wr   = accept && hit_any && cpu_we && wr_allowed;
    quick_rd = accept && hit_any && !cpu_we && !epp_on;
  end

endmodule

// File: rtl/epp_reg_bank.sv
module epp_reg_bank #(
  parameter int DW    = 8,
  parameter int NREG  = 2,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             cap_en,
  input  logic [IDX_W-1:0] cap_idx,
  input  logic [DW-1:0]    cap_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data
);

  logic [DW-1:0] reg_vals [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic          hit_wr;
    logic          hit_cap;
    logic          en;
    logic [DW-1:0] d;
    logic [DW-1:0] q;

    always_comb begin
      hit_wr  = wr_en  && (wr_idx  == IDX_W'(g));
      hit_cap = cap_en && (cap_idx == IDX_W'(g));
      en      = hit_wr || hit_cap;
      d       = hit_cap ? cap_data : wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= d;
      end
    end

    assign reg_vals[g] = q;
  end

  assign rd_data = reg_vals[rd_idx];

endmodule

// File: rtl/epp_cycle_seq.sv
module epp_cycle_seq
  import epp_host_pkg::*;
#(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  cyc_kind_t       kind_in,
  input  logic [TO_W-1:0] limit,
  input  logic            nwait,
  output logic            busy,
  output logic            nwrite_n,
  output logic            astrb_n,
  output logic            dstrb_n,
  output logic            d_oe,
  output logic            capture,
  output logic            done,
  output logic            abort,
  output cyc_kind_t       kind
);

  seq_state_e      state_q, state_d;
  cyc_kind_t       kind_q, kind_d;
  logic [TO_W-1:0] cnt_q, cnt_d;
  logic            to_en;
  logic            limit_hit;
  logic            strb_low;

  always_comb begin
    to_en     = (limit != '0);
    limit_hit = to_en && (cnt_q == TO_W'(limit - 1'b1));
  end

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    abort   = 1'b0;
    done    = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (launch) begin
          state_d = SEQ_SETUP;
          kind_d  = kind_in;
        end
      end
      SEQ_SETUP: begin
        state_d = SEQ_STROBE;
        cnt_d   = '0;
      end
      SEQ_STROBE: begin
        if (nwait) begin
          state_d = SEQ_RELEASE;
          cnt_d   = '0;
        end else if (limit_hit) begin
          state_d = SEQ_IDLE;
          abort   = 1'b1;
          done    = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_RELEASE: begin
        if (!nwait) begin
          state_d = SEQ_IDLE;
          done    = 1'b1;
        end else if (limit_hit) begin
          state_d = SEQ_IDLE;
          abort   = 1'b1;
          done    = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      kind_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    busy     = (state_q != SEQ_IDLE);
    nwrite_n = !(busy && !kind_q.is_read);
    d_oe     = busy && !kind_q.is_read;
    astrb_n  = !((state_q == SEQ_STROBE) && kind_q.is_addr);
    dstrb_n  = !((state_q == SEQ_STROBE) && !kind_q.is_addr);
    capture  = (state_q == SEQ_STROBE) && nwait && kind_q.is_read;
    kind     = kind_q;
    strb_low = !astrb_n || !dstrb_n;
  end

  AST_STRB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_low && !nwait && (limit == '0)) |=> strb_low);                 // R4
  AST_STRB_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_low && nwait) |=> !strb_low);                                  // R4
  AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb_low) |-> $past(busy));                                    // R4
  AST_ONE_STRB: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!astrb_n, !dstrb_n}));                                     // R10
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    nwrite_n |-> !d_oe);                                                 // R5
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!strb_low && nwrite_n));                                  // R8

endmodule

// File: rtl/epp_host_port.sv
module epp_host_port
  import epp_host_pkg::*;
#(
  parameter int DW       = 8,
  parameter int ADDR_W   = 3,
  parameter int TO_W     = 8,
  parameter int ADDR_OFS = 3,
  parameter int DATA_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [DW-1:0]     cpu_rdata,
  input  logic [2:0]        mode_sel,
  input  logic              auto_mode,
  input  logic [TO_W-1:0]   timeout_limit,
  output logic              timeout_flag,
  output logic              pp_nwrite,
  output logic              pp_nastrb,
  output logic              pp_ndstrb,
  input  logic              pp_nwait,
  output logic [DW-1:0]     pp_dout,
  output logic              pp_doe,
  input  logic [DW-1:0]     pp_din
);

  localparam int NREG = 2;

  logic      seq_busy;
  logic      launch;
  cyc_kind_t launch_kind;
  cyc_kind_t cur_kind;
  logic      reg_wr;
  logic      quick_rd;
  logic      sel_idx;
  logic      capture;
  logic      done;
  logic      abort;
  logic      rd_idx;
  logic [DW-1:0] bank_rd;
  logic [DW-1:0] bank_addr_q;

  logic          rvalid_q, rvalid_d;
  logic [DW-1:0] rdata_q;
  logic          rdata_en;
  logic          to_q, to_d;
  logic [DW-1:0] dout_q;
  logic          dout_en;

  epp_req_gate #(
    .ADDR_W  (ADDR_W),
    .ADDR_OFS(ADDR_OFS),
    .DATA_OFS(DATA_OFS)
  ) u_gate (
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .mode_sel   (mode_sel),
    .auto_mode  (auto_mode),
    .seq_busy   (seq_busy),
    .launch     (launch),
    .launch_kind(launch_kind),
    .reg_wr     (reg_wr),
    .quick_rd   (quick_rd),
    .sel_idx    (sel_idx)
  );

  epp_cycle_seq #(
    .TO_W(TO_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (launch),
    .kind_in (launch_kind),
    .limit   (timeout_limit),
    .nwait   (pp_nwait),
    .busy    (seq_busy),
    .nwrite_n(pp_nwrite),
    .astrb_n (pp_nastrb),
    .dstrb_n (pp_ndstrb),
    .d_oe    (pp_doe),
    .capture (capture),
    .done    (done),
    .abort   (abort),
    .kind    (cur_kind)
  );

  always_comb rd_idx = quick_rd ? sel_idx : !cur_kind.is_addr;

  epp_reg_bank #(
    .DW  (DW),
    .NREG(NREG)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .wr_idx  (sel_idx),
    .wr_data (cpu_wdata),
    .cap_en  (capture),
    .cap_idx (!cur_kind.is_addr),
    .cap_data(pp_din),
    .rd_idx  (rd_idx),
    .rd_data (bank_rd)
  );

  assign bank_addr_q = bank_rd;

  always_comb begin
    rvalid_d = quick_rd || (done && cur_kind.is_read);
    rdata_en = rvalid_d;
    to_d     = to_q || abort;
    dout_en  = reg_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      to_q     <= 1'b0;
    end else begin
      rvalid_q <= rvalid_d;
      to_q     <= to_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= bank_addr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
    end else if (dout_en) begin
      dout_q <= cpu_wdata;
    end
  end

  assign cpu_ready    = !seq_busy;
  assign cpu_rvalid   = rvalid_q;
  assign cpu_rdata    = rdata_q;
  assign timeout_flag = to_q;
  assign pp_dout      = dout_q;

  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |=> timeout_flag);                                      // R8
  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_ready && cpu_we && (auto_mode || mode_sel != MODE_EPP))
      |=> cpu_ready);                                                    // R3
  AST_QUICK_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_ready && !cpu_we && (mode_sel != MODE_EPP) &&
     ((cpu_addr == ADDR_W'(ADDR_OFS)) || (cpu_addr == ADDR_W'(DATA_OFS))))
      |=> (cpu_rvalid && cpu_ready));                                    // R6
  AST_BUSY_NO_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_ready && $past(!cpu_ready) && $past(pp_nastrb && pp_ndstrb && !done, 1))
      |-> !cpu_rvalid || $past(done, 1));                                // R7

endmodule

// File: tb/epp_host_port_test.sv
module epp_host_port_test;

  localparam int DW   = 8;
  localparam int AW   = 3;
  localparam int TO_W = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0;
  logic          cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready;
  logic          cpu_rvalid;
  logic [DW-1:0] cpu_rdata;
  logic [2:0]    mode_sel = 3'b100;
  logic          auto_mode = 1'b0;
  logic [TO_W-1:0] timeout_limit = '0;
  logic          timeout_flag;
  logic          pp_nwrite, pp_nastrb, pp_ndstrb;
  logic          pp_nwait = 1'b0;
  logic [DW-1:0] pp_dout;
  logic          pp_doe;
  logic [DW-1:0] pp_din;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // peripheral model state
  int        per_dly = 1;
  bit        per_hold = 1'b0;
  int        per_cnt = 0;
  logic [7:0] per_addr_val = 8'h00;
  logic [7:0] per_data_val = 8'h00;
  logic [7:0] per_addr_got = 8'h00;
  logic [7:0] per_data_got = 8'h00;
  bit        per_last_is_addr = 1'b0;
  bit        per_last_nwrite = 1'b1;
  bit        per_last_oe = 1'b0;
  int        per_strobes = 0;
  int        strb_width = 0;
  int        last_width = 0;
  bit        prev_strb = 1'b0;
  bit        overlap_seen = 1'b0;
  bit        drive_bad = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2 clk = ~clk;

  epp_host_port #(
    .DW    (DW),
    .ADDR_W(AW),
    .TO_W  (TO_W)
  ) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .cpu_ready    (cpu_ready),
    .cpu_rvalid   (cpu_rvalid),
    .cpu_rdata    (cpu_rdata),
    .mode_sel     (mode_sel),
    .auto_mode    (auto_mode),
    .timeout_limit(timeout_limit),
    .timeout_flag (timeout_flag),
    .pp_nwrite    (pp_nwrite),
    .pp_nastrb    (pp_nastrb),
    .pp_ndstrb    (pp_ndstrb),
    .pp_nwait     (pp_nwait),
    .pp_dout      (pp_dout),
    .pp_doe       (pp_doe),
    .pp_din       (pp_din)
  );

  assign pp_din = !pp_nastrb ? per_addr_val : (!pp_ndstrb ? per_data_val : 8'h00);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // peripheral handshake model and port monitor
  always @(negedge clk) begin
    if (rst_n) begin
      bit sl;
      sl = !pp_nastrb || !pp_ndstrb;
      if (!pp_nastrb && !pp_ndstrb) overlap_seen = 1'b1;
      if (pp_doe && pp_nwrite) drive_bad = 1'b1;
      if (sl && !prev_strb) per_strobes++;
      if (sl) strb_width++;
      else if (prev_strb) begin
        last_width = strb_width;
        strb_width = 0;
      end
      prev_strb = sl;
      if (sl && !pp_nwait) begin
        if (!per_hold) begin
          per_cnt++;
          if (per_cnt >= per_dly) begin
            per_cnt = 0;
            pp_nwait = 1'b1;
            per_last_is_addr = !pp_nastrb;
            per_last_nwrite = pp_nwrite;
            per_last_oe = pp_doe;
            if (!pp_nwrite) begin
              if (!pp_nastrb) per_addr_got = pp_dout;
              else per_data_got = pp_dout;
            end
          end
        end
      end else if (!sl && pp_nwait) begin
        per_cnt++;
        if (per_cnt >= per_dly) begin
          per_cnt = 0;
          pp_nwait = 1'b0;
        end
      end
    end
  end

  // scoreboard monitor for read results
  always @(negedge clk) begin
    if (rst_n && cpu_rvalid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected rvalid", cpu_rdata, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(cpu_rdata == e, t, cpu_rdata, e);
      end
    end
  end

  task automatic issue(input bit we, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_req = 1'b1;
    cpu_we = we;
    cpu_addr = a;
    cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic wait_done();
    repeat (2) @(negedge clk);
    while (!cpu_ready || pp_nwait) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_rd(input logic [7:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(pp_nastrb && pp_ndstrb, "R1 strobes high", {pp_nastrb, pp_ndstrb}, 3);
    chk(pp_nwrite && !pp_doe, "R1 write line/oe", {pp_nwrite, pp_doe}, 2);
    chk(cpu_ready && !cpu_rvalid && !timeout_flag, "R1 ready/rvalid/timeout",
        {cpu_ready, cpu_rvalid, timeout_flag}, 4);

    // R2 address write, R4 width with delay 1
    per_dly = 1;
    issue(1'b1, 3'd3, 8'h5A);
    wait_done();
    chk(per_addr_got == 8'h5A && per_last_is_addr, "R2 address write byte",
        per_addr_got, 8'h5A);
    chk(!per_last_nwrite && per_last_oe, "R2 address write drives bus",
        {per_last_nwrite, per_last_oe}, 1);
    chk(last_width == 1, "R4 strobe width delay 1", last_width, 1);

    // R2 data write, R4 width with delay 3
    per_dly = 3;
    issue(1'b1, 3'd4, 8'hC3);
    wait_done();
    chk(per_data_got == 8'hC3 && !per_last_is_addr, "R2 data write byte",
        per_data_got, 8'hC3);
    chk(last_width == 3, "R4 strobe width delay 3", last_width, 3);

    // R5 EPP reads
    per_data_val = 8'h7E;
    expect_rd(8'h7E, "R5 data read");
    issue(1'b0, 3'd4, 8'h00);
    wait_done();
    chk(per_last_nwrite && !per_last_oe && !per_last_is_addr, "R5 read bus released",
        {per_last_nwrite, per_last_oe}, 2);
    per_dly = 1;
    per_addr_val = 8'h21;
    expect_rd(8'h21, "R5 address read");
    issue(1'b0, 3'd3, 8'h00);
    wait_done();
    auto_mode = 1'b1;
    per_data_val = 8'h44;
    expect_rd(8'h44, "R5 read with auto flag set");
    issue(1'b0, 3'd4, 8'h00);
    wait_done();
    auto_mode = 1'b0;

    // R6 reads outside EPP mode
    mode_sel = 3'b001;
    s0 = per_strobes;
    expect_rd(8'h44, "R6 held data byte");
    issue(1'b0, 3'd4, 8'h00);
    chk(cpu_rvalid && cpu_ready, "R6 rvalid next cycle", {cpu_rvalid, cpu_ready}, 3);
    expect_rd(8'h21, "R6 held address byte");
    issue(1'b0, 3'd3, 8'h00);
    wait_done();
    chk(per_strobes == s0, "R6 no strobe", per_strobes, s0);

    // R3 ignored writes
    issue(1'b1, 3'd4, 8'hEE);
    wait_done();
    chk(per_strobes == s0, "R3 write in other mode no strobe", per_strobes, s0);
    expect_rd(8'h44, "R3 data register unchanged");
    issue(1'b0, 3'd4, 8'h00);
    wait_done();
    mode_sel = 3'b100;
    auto_mode = 1'b1;
    issue(1'b1, 3'd3, 8'hEE);
    wait_done();
    chk(per_strobes == s0, "R3 write with auto flag no strobe", per_strobes, s0);
    auto_mode = 1'b0;
    mode_sel = 3'b000;
    expect_rd(8'h21, "R3 address register unchanged");
    issue(1'b0, 3'd3, 8'h00);
    wait_done();
    mode_sel = 3'b100;

    // R9 other offsets
    issue(1'b1, 3'd5, 8'h12);
    issue(1'b0, 3'd0, 8'h00);
    issue(1'b0, 3'd5, 8'h00);
    wait_done();
    chk(per_strobes == s0, "R9 unused offsets no strobe", per_strobes, s0);
    chk(exp_q.size() == 0, "R9 no pending reads", exp_q.size(), 0);

    // R7 stall while busy
    per_dly = 3;
    issue(1'b1, 3'd4, 8'h11);
    chk(!cpu_ready, "R7 busy during transfer", cpu_ready, 0);
    cpu_req = 1'b1;
    cpu_we = 1'b1;
    cpu_addr = 3'd4;
    cpu_wdata = 8'h99;
    repeat (2) @(negedge clk);
    cpu_req = 1'b0;
    wait_done();
    chk(per_strobes == s0 + 1, "R7 single transfer", per_strobes, s0 + 1);
    chk(per_data_got == 8'h11, "R7 peripheral saw first byte", per_data_got, 8'h11);
    mode_sel = 3'b000;
    expect_rd(8'h11, "R7 register holds first byte");
    issue(1'b0, 3'd4, 8'h00);
    wait_done();
    mode_sel = 3'b100;

    // R8 timeout disabled, long wait
    timeout_limit = '0;
    per_dly = 20;
    issue(1'b1, 3'd3, 8'h3C);
    wait_done();
    chk(last_width == 20 && !timeout_flag, "R8 limit 0 waits", last_width, 20);
    chk(per_addr_got == 8'h3C, "R8 long write completes", per_addr_got, 8'h3C);

    // R8 timeout abort
    timeout_limit = 4'd5;
    per_hold = 1'b1;
    per_dly = 1;
    issue(1'b1, 3'd4, 8'hA5);
    wait_done();
    chk(last_width == 5, "R8 abort after limit", last_width, 5);
    chk(timeout_flag && cpu_ready && pp_nwrite, "R8 idle with flag",
        {timeout_flag, cpu_ready, pp_nwrite}, 7);
    per_hold = 1'b0;
    issue(1'b1, 3'd4, 8'h66);
    wait_done();
    chk(per_data_got == 8'h66 && timeout_flag, "R8 flag sticky", timeout_flag, 1);

    // R10 port rules over the whole run
    chk(!overlap_seen, "R10 strobes never both low", overlap_seen, 0);
    chk(!drive_bad, "R10 bus driven only in writes", drive_bad, 0);
    chk(exp_q.size() == 0, "R5 all reads returned", exp_q.size(), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule